// File: doc/BRIEF.md
# Status Register and Write Guard

This unit sits between the serial command decoder of a small serial EEPROM and its programming sequencer. It holds the status byte the host polls, made up of three non-volatile fields (a status-lock bit and a two-bit protected-region size) and two volatile flags (the write-enable latch and the write-busy flag). It decides whether a status update may be taken, and whether a given array byte address lies inside the protected region.

The decoder sends single-cycle strobes for "enable writes", "disable writes" and "update status" with the new byte. The sequencer drives a busy level for the whole programming cycle and a one-cycle completion strobe at its end. An accepted status update is held as pending. It becomes visible only when the sequencer reports completion, so the readable lock and region bits stay frozen while the cycle runs. A power-on reset returns everything to 0x00. A soft reset clears only the volatile state and keeps the non-volatile fields.

Top module: `sr_protect_unit`

## Requirements
- R1: After power-on reset (por_n low) the status byte reads 0x00, sr_wr_ok is 0 and no address is protected.
- R2: A cmd_wren strobe sets the enable latch (bit 1) and a cmd_wrdi strobe clears it. When both come in the same cycle, the latch is cleared. Both are ignored while busy is high.
- R3: Status bits 6..4 always read 0. Bit 0 follows the busy input in the same cycle. Bit 1 shows the enable latch.
- R4: The enable latch is cleared at the completion of any programming cycle (wr_done high together with busy), including when cmd_wren arrives in that same cycle. A soft reset (rst_n low at an edge) also clears it and keeps bits 7, 3 and 2.
- R5: sr_wr_ok is high exactly when the latch is set, busy is low, and hardware lock is not active. With bit 7 at 0 the level of wp_n has no effect.
- R6: Hardware lock is active when bit 7 is 1 and wp_n is low. A status update requested then is discarded and the stored value is kept. Raising wp_n ends the lock, and bits 3..2 are unchanged.
- R7: An accepted update takes only bits 7, 3 and 2 of sr_wdata. Those bits keep their old value while busy is high, and the new value appears in the cycle after the completion edge.
- R8: With a memory of 2^ADDR_W bytes, the region code in bits 3..2 gives: 00 nothing protected, 01 the upper quarter, 10 the upper half, 11 all addresses. addr_prot reports this for chk_addr in the same cycle.
- R9: An update request made while sr_wr_ok is low leaves no pending value, so a later completion does not change the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears every bit |
| rst_n | input | 1 | Synchronous soft reset, active low; clears volatile state only |
| cmd_wren | input | 1 | Strobe: set the enable latch |
| cmd_wrdi | input | 1 | Strobe: clear the enable latch |
| sr_wr_req | input | 1 | Strobe: request a status update with sr_wdata |
| sr_wdata | input | 8 | New status byte; bits 7, 3, 2 used |
| wp_n | input | 1 | Write-protect pin, low asserts protection |
| busy | input | 1 | Programming cycle in progress |
| wr_done | input | 1 | Programming cycle completes this cycle |
| chk_addr | input | ADDR_W | Array byte address to classify |
| sr_rdata | output | 8 | Readable status byte |
| sr_wr_ok | output | 1 | Status update permitted now |
| addr_prot | output | 1 | chk_addr lies in the protected region |

## Verification
The case that matters is a programming cycle that completes in the same cycle as an enable strobe: completion clears the latch, and the strobe must not set it again. The bench raises cmd_wren on the cycle in which wr_done and busy are both high and expects bit 1 to read 0 afterwards. A second overlap is a disable strobe together with an enable strobe, where the latch must end up clear. A behavioural model updated on every edge judges all three outputs in every cycle, including while busy is high, where bits 7..2 must not move.

// File: rtl/srp_pkg.sv
package srp_pkg;
    localparam int SR_W = 8;

    // non-volatile part of the status byte
    typedef struct packed {
        logic       lock;
        logic [1:0] region;
    } nv_t;

    typedef struct packed {
        nv_t  nv;
        nv_t  pend;
        logic pend_v;
        logic wel;
    } st_t;
endpackage

// File: rtl/srp_wr_gate.sv
module srp_wr_gate (
    input  logic lock,
    input  logic wp_n,
    input  logic wel,
    input  logic busy,
    output logic hw_lock,
    output logic wr_ok
);
    always_comb begin
        hw_lock = lock & ~wp_n;
        wr_ok   = wel & ~busy & ~hw_lock;
    end
endmodule

// File: rtl/srp_range_dec.sv
module srp_range_dec #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        region,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam logic [ADDR_W-1:0] HALF_BASE  = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] QUART_BASE = ADDR_W'(3) << (ADDR_W - 2);

    always_comb begin
        unique case (region)
            2'b00:   prot = 1'b0;
            2'b01:   prot = (addr >= QUART_BASE);
            2'b10:   prot = (addr >= HALF_BASE);
            default: prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/srp_state.sv
module srp_state
    import srp_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic cmd_wren,
    input  logic cmd_wrdi,
    input  logic upd_acc,
    input  nv_t  upd_nv,
    input  logic busy,
    input  logic wr_done,
    output nv_t  nv_q,
    output logic wel_q
);
    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!busy) begin
            if (cmd_wrdi)      st_d.wel = 1'b0;
            else if (cmd_wren) st_d.wel = 1'b1;
        end
        if (upd_acc) begin
            st_d.pend   = upd_nv;
            st_d.pend_v = 1'b1;
        end
        if (busy && wr_done) begin
            st_d.wel    = 1'b0;
            st_d.pend_v = 1'b0;
            if (st_q.pend_v) st_d.nv = st_q.pend;
        end
        if (!rst_n) begin
            st_d.wel    = 1'b0;
            st_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nv_q  = st_q.nv;
    assign wel_q = st_q.wel;
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
    import srp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              sr_wr_req,
    input  logic [SR_W-1:0]   sr_wdata,
    input  logic              wp_n,
    input  logic              busy,
    input  logic              wr_done,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [SR_W-1:0]   sr_rdata,
    output logic              sr_wr_ok,
    output logic              addr_prot
);
    nv_t  nv_q;
    nv_t  upd_nv;
    logic wel_q;
    logic hw_lock;
    logic unused_wbits;

    assign upd_nv       = '{lock: sr_wdata[7], region: sr_wdata[3:2]};
    assign unused_wbits = ^{sr_wdata[6:4], sr_wdata[1:0], hw_lock};

    srp_wr_gate u_gate (
        .lock    (nv_q.lock),
        .wp_n    (wp_n),
        .wel     (wel_q),
        .busy    (busy),
        .hw_lock (hw_lock),
        .wr_ok   (sr_wr_ok)
    );

    srp_state u_state (
        .clk      (clk),
        .por_n    (por_n),
        .rst_n    (rst_n),
        .cmd_wren (cmd_wren),
        .cmd_wrdi (cmd_wrdi),
        .upd_acc  (sr_wr_req & sr_wr_ok),
        .upd_nv   (upd_nv),
        .busy     (busy),
        .wr_done  (wr_done),
        .nv_q     (nv_q),
        .wel_q    (wel_q)
    );

    srp_range_dec #(.ADDR_W(ADDR_W)) u_dec (
        .region (nv_q.region),
        .addr   (chk_addr),
        .prot   (addr_prot)
    );

    assign sr_rdata = {nv_q.lock, 3'b000, nv_q.region, wel_q, busy};
endmodule

// File: rtl/srp_checker.sv
module srp_checker (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       busy,
    input logic       wr_done,
    input logic       wp_n,
    input logic [7:0] sr_rdata,
    input logic       sr_wr_ok,
    input logic       addr_prot
);
    a_r2_wren_sets: assert property (@(posedge clk) disable iff (!por_n)
        (cmd_wren && !cmd_wrdi && !busy && rst_n) |=> sr_rdata[1]);

    a_r2_wrdi_clears: assert property (@(posedge clk) disable iff (!por_n)
        (cmd_wrdi && !busy) |=> !sr_rdata[1]);

    a_r4_done_clears: assert property (@(posedge clk) disable iff (!por_n)
        (wr_done && busy) |=> !sr_rdata[1]);

    a_r3_fixed_bits: assert property (@(posedge clk) disable iff (!por_n)
        (sr_rdata[6:4] == 3'b000) && (sr_rdata[0] == busy));

    a_r6_lock_blocks: assert property (@(posedge clk) disable iff (!por_n)
        (sr_rdata[7] && !wp_n) |-> !sr_wr_ok);

    a_r7_frozen: assert property (@(posedge clk) disable iff (!por_n)
        (busy && !wr_done) |=> $stable(sr_rdata[7:2]));

    a_r8_all_prot: assert property (@(posedge clk) disable iff (!por_n)
        (sr_rdata[3:2] == 2'b11) |-> addr_prot);

    a_r8_none_prot: assert property (@(posedge clk) disable iff (!por_n)
        (sr_rdata[3:2] == 2'b00) |-> !addr_prot);
endmodule

bind sr_protect_unit srp_checker u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .cmd_wren  (cmd_wren),
    .cmd_wrdi  (cmd_wrdi),
    .busy      (busy),
    .wr_done   (wr_done),
    .wp_n      (wp_n),
    .sr_rdata  (sr_rdata),
    .sr_wr_ok  (sr_wr_ok),
    .addr_prot (addr_prot)
);

// File: tb/tb_sr_protect_unit.sv
module tb_sr_protect_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 11;
    localparam int DEPTH      = 1 << AW;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          rst_n = 1'b1;
    logic          cmd_wren = 1'b0;
    logic          cmd_wrdi = 1'b0;
    logic          sr_wr_req = 1'b0;
    logic [7:0]    sr_wdata = 8'h00;
    logic          wp_n = 1'b1;
    logic          busy = 1'b0;
    logic          wr_done = 1'b0;
    logic [AW-1:0] chk_addr = '0;
    logic [7:0]    sr_rdata;
    logic          sr_wr_ok;
    logic          addr_prot;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_protect_unit #(.ADDR_W(AW)) dut (.*);

    // behavioural reference
    int m_lock = 0, m_region = 0, m_wel = 0;
    int p_valid = 0, p_lock = 0, p_region = 0;

    always @(posedge clk) begin
        int ok;
        if (!por_n) begin
            m_lock = 0; m_region = 0; m_wel = 0; p_valid = 0;
        end else begin
            ok = (m_wel == 1 && !busy && !(m_lock == 1 && !wp_n)) ? 1 : 0;
            if (busy && wr_done) begin
                m_wel = 0;
                if (p_valid == 1) begin m_lock = p_lock; m_region = p_region; end
                p_valid = 0;
            end else begin
                if (!busy && cmd_wrdi)      m_wel = 0;
                else if (!busy && cmd_wren) m_wel = 1;
                if (sr_wr_req && ok == 1) begin
                    p_valid = 1; p_lock = sr_wdata[7]; p_region = sr_wdata[3:2];
                end
            end
            if (!rst_n) begin m_wel = 0; p_valid = 0; end
        end
    end

    function automatic int exp_byte();
        if (!por_n) return {24'd0, 7'd0, busy};
        return m_lock * 128 + m_region * 4 + m_wel * 2 + (busy ? 1 : 0);
    endfunction

    function automatic int exp_ok();
        if (!por_n) return 0;
        return (m_wel == 1 && !busy && !(m_lock == 1 && !wp_n)) ? 1 : 0;
    endfunction

    function automatic int exp_prot();
        int a = int'(chk_addr);
        if (!por_n) return 0;
        case (m_region)
            1:       return (a >= (DEPTH / 4) * 3) ? 1 : 0;
            2:       return (a >= DEPTH / 2) ? 1 : 0;
            3:       return 1;
            default: return 0;
        endcase
    endfunction

    string cur_req = "R1";
    int pc_total = 0, pc_bad = 0;

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        pc_total += 3;
        if (int'(sr_rdata) != exp_byte()) begin
            pc_bad++;
            $display("FAIL %s cycle status byte act=%02h exp=%02h", cur_req, sr_rdata, exp_byte());
        end
        if (int'(sr_wr_ok) != exp_ok()) begin
            pc_bad++;
            $display("FAIL %s cycle wr_ok act=%0d exp=%0d", cur_req, sr_wr_ok, exp_ok());
        end
        if (int'(addr_prot) != exp_prot()) begin
            pc_bad++;
            $display("FAIL %s cycle prot act=%0d exp=%0d", cur_req, addr_prot, exp_prot());
        end
    end

    int st_total = 0, st_bad = 0;
    bit finished = 0;

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [7:0] e_byte, logic e_ok);
        @(negedge clk); #1;
        st_total += 2;
        if (sr_rdata !== e_byte) begin
            st_bad++;
            $display("FAIL %s status byte act=%02h exp=%02h", req, sr_rdata, e_byte);
        end
        if (sr_wr_ok !== e_ok) begin
            st_bad++;
            $display("FAIL %s wr_ok act=%0d exp=%0d", req, sr_wr_ok, e_ok);
        end
    endtask

    task automatic chk_prot(string req, int addr, logic e);
        @(posedge clk); #1;
        chk_addr = AW'(addr);
        @(negedge clk); #1;
        st_total++;
        if (addr_prot !== e) begin
            st_bad++;
            $display("FAIL %s prot addr=%03h act=%0d exp=%0d", req, addr, addr_prot, e);
        end
    endtask

    task automatic wren();
        cmd_wren = 1'b1; tick(); cmd_wren = 1'b0;
    endtask

    task automatic upd(logic [7:0] v);
        sr_wr_req = 1'b1; sr_wdata = v; tick(); sr_wr_req = 1'b0;
    endtask

    task automatic complete(int n);
        busy = 1'b1;
        for (int i = 0; i < n; i++) tick();
        wr_done = 1'b1; tick(); wr_done = 1'b0; busy = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", st_total + pc_total + 1, st_bad + pc_bad + 1);
            $finish;
        end
    end

    initial begin
        // R1 power-on state
        tick(); tick(); tick();
        por_n = 1'b1;
        tick();
        chk("R1", 8'h00, 1'b0);
        chk_prot("R1", DEPTH - 1, 1'b0);

        // R2 latch set / clear / overlap
        cur_req = "R2";
        wren();                              chk("R2", 8'h02, 1'b1);
        cmd_wrdi = 1'b1; tick(); cmd_wrdi = 1'b0; chk("R2", 8'h00, 1'b0);
        cmd_wren = 1'b1; cmd_wrdi = 1'b1; tick();
        cmd_wren = 1'b0; cmd_wrdi = 1'b0;    chk("R2", 8'h00, 1'b0);

        // R5 lock bit clear: pin level irrelevant
        cur_req = "R5";
        wren(); wp_n = 1'b0;                 chk("R5", 8'h02, 1'b1);
        upd(8'hFF);
        // R7 frozen during busy; R3 busy bit live
        cur_req = "R7";
        busy = 1'b1; tick();                 chk("R3", 8'h03, 1'b0);
        cmd_wrdi = 1'b1; tick(); cmd_wrdi = 1'b0; chk("R2", 8'h03, 1'b0);
        wr_done = 1'b1; tick(); wr_done = 1'b0; busy = 1'b0;
        chk("R7", 8'h8C, 1'b0);
        chk_prot("R8", 0, 1'b1);

        // R6 hardware lock
        cur_req = "R6";
        wren();                              chk("R6", 8'h8E, 1'b0);
        upd(8'h00);
        complete(2);                         chk("R6", 8'h8C, 1'b0);
        wp_n = 1'b1; wren();                 chk("R6", 8'h8E, 1'b1);

        // R8 upper quarter
        cur_req = "R8";
        upd(8'h04); complete(1);             chk("R7", 8'h04, 1'b0);
        chk_prot("R8", (DEPTH / 4) * 3 - 1, 1'b0);
        chk_prot("R8", (DEPTH / 4) * 3, 1'b1);

        // R4 soft reset keeps non-volatile bits
        cur_req = "R4";
        wren();                              chk("R4", 8'h06, 1'b1);
        rst_n = 1'b0; tick(); rst_n = 1'b1;  chk("R4", 8'h04, 1'b0);

        // R8 upper half
        cur_req = "R8";
        wren(); upd(8'h08); complete(1);     chk("R8", 8'h08, 1'b0);
        chk_prot("R8", DEPTH / 2 - 1, 1'b0);
        chk_prot("R8", DEPTH / 2, 1'b1);

        // R4 array completion with simultaneous enable strobe
        cur_req = "R4";
        wren(); busy = 1'b1; tick();         chk("R4", 8'h0B, 1'b0);
        wr_done = 1'b1; cmd_wren = 1'b1; tick();
        wr_done = 1'b0; cmd_wren = 1'b0; busy = 1'b0;
        chk("R4", 8'h08, 1'b0);

        // R8 nothing protected
        cur_req = "R8";
        wren(); upd(8'h00); complete(1);     chk("R8", 8'h00, 1'b0);
        chk_prot("R8", DEPTH - 1, 1'b0);

        // R9 refused request leaves nothing pending
        cur_req = "R9";
        upd(8'h8C);                          chk("R9", 8'h00, 1'b0);
        complete(1);                         chk("R9", 8'h00, 1'b0);

        tick(); tick();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", st_total + pc_total, st_bad + pc_bad);
        $finish;
    end
endmodule